// File: doc/BRIEF.md
# Look-ahead pipelined first-order IIR low-pass

This block filters a stream of signed fixed-point samples with the first-order recursion y(n+1) = a·y(n) + b·x(n). The recursion is unrolled by one step, so the feedback path computes y(n+2) = a²·y(n) + a·b·x(n) + b·x(n+1). The loop therefore holds two registers: one after the multiplier and one after the adder. The multiply-add gets a full clock cycle for each half and does not limit the clock rate. The two input terms form a short feed-forward section with a parameterised number of pipeline registers. Those registers sit outside the loop.

The coefficients a and b are signed Q1.16 values in 18 bits. Each is written through a one-word write port. The block forms a², a·b and b from them at full precision, then rounds and clamps each one back to the coefficient width. One sample is accepted on each clock in which the input strobe is high. Every register, including the loop, advances only on accepted samples. Each result is rounded to nearest and clamped to the sample width. It is presented with a one-cycle valid pulse.

Top module: `iir_la_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` = 0 and `out_data` = 0. The loop, the feed-forward registers, the valid pipeline and both coefficients are all cleared.
- R2: A write with `coef_we` = 1 stores `coef_wdata` as a when `coef_sel` = 0 and as b when `coef_sel` = 1. Both are signed Q1.16 (value = code / 65536). The derived set a², a·b, b is in use from the second clock edge after the write. With dyadic coefficients the first outputs of an impulse response are exact.
- R3: For impulse, step and random inputs, each output lies within 3 LSB of round(y), where y follows y ← a·y + b·x once per accepted sample, starting from 0.
- R4: Results are rounded half-up to an integer sample. Values above 32767 come out as exactly 32767, and values below -32768 come out as exactly -32768.
- R5: With FIR_STAGES = S, the result of accepted sample j appears on the clock edge that accepts sample j+S+1. `out_valid` is high for exactly the one cycle after that edge.
- R6: A clock edge with `in_valid` low changes no state. The cycle after it shows `out_valid` = 0 and `out_data` unchanged.
- R7: After reset, the first S+1 accepted samples produce no `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample accept strobe |
| in_data | input | DW | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_sel | input | 1 | 0 writes a, 1 writes b |
| coef_wdata | input | CW | Signed Q1.16 coefficient code |
| out_valid | output | 1 | One-cycle pulse per produced result |
| out_data | output | DW | Rounded, clamped filter output |

## Verification
The impulse pattern uses dyadic coefficients, where every value is exact. There it separates a from a² and a·b from b, and it exposes an off-by-one delay between the even and odd halves of the interleaved loop. Step patterns at unit and triple DC gain check steady-state gain and the exact clamp values at both rails. Random samples with idle gaps, at positive and negative pole positions, are compared against a real-valued model of the plain recursion. They show whether idle cycles leak into the loop state, and they confirm the fill and latency timing of the valid pulse.

// File: rtl/iir_la_pkg.sv
package iir_la_pkg;
   // Coefficient select encoding on the write port
   typedef enum logic {
      SEL_POLE = 1'b0,
      SEL_GAIN = 1'b1
   } coef_sel_e;
endpackage

// File: rtl/iir_la_rndsat.sv
// Round half-up by SH fractional bits, then clamp to OW signed bits.
module iir_la_rndsat #(
   parameter int IW = 36,
   parameter int SH = 16,
   parameter int OW = 16
) (
   input  logic signed [IW-1:0] d,
   output logic signed [OW-1:0] q
);
   localparam int EW = IW + 1;
   localparam int TW = EW - SH;
   localparam logic signed [EW-1:0] HALF = EW'(1) <<< (SH - 1);

   if (SH < 1)  begin : g_bad_sh  $error("SH must be at least 1");  end
   if (TW < 2)  begin : g_bad_tw  $error("too few bits left after shift"); end

   logic signed [EW-1:0] ext;
   logic signed [EW-1:0] sum;
   logic signed [TW-1:0] shr;

   assign ext = {d[IW-1], d};
   assign sum = ext + HALF;
   assign shr = sum[EW-1:SH];

   if (TW > OW) begin : g_sat
      localparam logic signed [TW-1:0] MAXV = {{(TW-OW+1){1'b0}}, {(OW-1){1'b1}}};
      localparam logic signed [TW-1:0] MINV = {{(TW-OW+1){1'b1}}, {(OW-1){1'b0}}};
      always_comb begin
         if (shr > MAXV)      q = MAXV[OW-1:0];
         else if (shr < MINV) q = MINV[OW-1:0];
         else                 q = shr[OW-1:0];
      end
   end else begin : g_ext
      assign q = OW'(shr);
   end
endmodule

// File: rtl/iir_la_coef.sv
// Coefficient store; derives loop and feed-forward coefficients.
module iir_la_coef
   import iir_la_pkg::*;
#(
   parameter int CW = 18,
   parameter int CF = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 wr_sel,
   input  logic signed [CW-1:0] wr_data,
   output logic signed [CW-1:0] k_loop,
   output logic signed [CW-1:0] k_old,
   output logic signed [CW-1:0] k_new
);
   localparam int PW = 2 * CW;

   logic signed [CW-1:0] pole_q, gain_q;
   logic signed [PW-1:0] pp_full, pg_full;
   logic signed [CW-1:0] pp_rnd, pg_rnd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pole_q <= '0;
         gain_q <= '0;
      end else if (wr_en) begin
         if (wr_sel == SEL_POLE) pole_q <= wr_data;
         else                    gain_q <= wr_data;
      end
   end

   assign pp_full = pole_q * pole_q;
   assign pg_full = pole_q * gain_q;

   iir_la_rndsat #(.IW(PW), .SH(CF), .OW(CW)) u_rs_pp (.d(pp_full), .q(pp_rnd));
   iir_la_rndsat #(.IW(PW), .SH(CF), .OW(CW)) u_rs_pg (.d(pg_full), .q(pg_rnd));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         k_loop <= '0;
         k_old  <= '0;
         k_new  <= '0;
      end else begin
         k_loop <= pp_rnd;
         k_old  <= pg_rnd;
         k_new  <= gain_q;
      end
   end
endmodule

// File: rtl/iir_la_fir.sv
// Feed-forward part: k_old*x(n) + k_new*x(n+1), then STAGES registers.
module iir_la_fir #(
   parameter int DW     = 16,
   parameter int CW     = 18,
   parameter int YW     = 36,
   parameter int STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [DW-1:0] x,
   input  logic signed [CW-1:0] k_old,
   input  logic signed [CW-1:0] k_new,
   output logic signed [YW-1:0] ff
);
   localparam int MW = CW + DW;

   logic signed [DW-1:0] x_prev;
   logic signed [MW-1:0] p_old, p_new;
   logic signed [YW-1:0] f_sum;
   logic signed [YW-1:0] pipe [STAGES];

   assign p_old = k_old * x_prev;
   assign p_new = k_new * x;
   assign f_sum = YW'(p_old) + YW'(p_new);

   always_ff @(posedge clk) begin
      if (!rst_n)  x_prev <= '0;
      else if (en) x_prev <= x;
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)  pipe[s] <= '0;
         else if (en) pipe[s] <= (s == 0) ? f_sum : pipe[(s == 0) ? 0 : s - 1];
      end
   end

   assign ff = pipe[STAGES-1];
endmodule

// File: rtl/iir_la_loop.sv
// Recursive part: two registers in the loop, y <= k_loop*y(two back) + ff.
module iir_la_loop #(
   parameter int CW = 18,
   parameter int CF = 16,
   parameter int YW = 36
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [CW-1:0] k_loop,
   input  logic signed [YW-1:0] ff,
   output logic signed [YW-1:0] y
);
   localparam int PW = CW + YW;

   logic signed [PW-1:0] prod;
   logic signed [YW-1:0] m_nx, m_q, y_q;

   assign prod = k_loop * y_q;

   iir_la_rndsat #(.IW(PW), .SH(CF), .OW(YW)) u_rs_m (.d(prod), .q(m_nx));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_q <= '0;
         y_q <= '0;
      end else if (en) begin
         m_q <= m_nx;
         y_q <= m_q + ff;
      end
   end

   assign y = y_q;
endmodule

// File: rtl/iir_la_top.sv
module iir_la_top #(
   parameter int DW         = 16,
   parameter int CW         = 18,
   parameter int CF         = 16,
   parameter int GB         = 4,
   parameter int FIR_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_data,
   input  logic                 coef_we,
   input  logic                 coef_sel,
   input  logic signed [CW-1:0] coef_wdata,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_data
);
   localparam int YW  = DW + CF + GB;
   localparam int LAT = FIR_STAGES + 1;

   if (FIR_STAGES < 1)      begin : g_bad_stg  $error("FIR_STAGES must be >= 1"); end
   if (DW < 2)              begin : g_bad_dw   $error("DW must be >= 2"); end
   if (CW <= CF)            begin : g_bad_cw   $error("CW needs an integer bit above CF"); end
   if (CF + GB < CW + 1)    begin : g_bad_gb   $error("GB too small for feed-forward sum"); end

   logic signed [CW-1:0] k_loop, k_old, k_new;
   logic signed [YW-1:0] ff, y_acc;
   logic signed [DW-1:0] y_rnd;
   logic [LAT-1:0]       vpipe;

   iir_la_coef #(.CW(CW), .CF(CF)) u_coef (
      .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_sel(coef_sel),
      .wr_data(coef_wdata), .k_loop(k_loop), .k_old(k_old), .k_new(k_new)
   );

   iir_la_fir #(.DW(DW), .CW(CW), .YW(YW), .STAGES(FIR_STAGES)) u_fir (
      .clk(clk), .rst_n(rst_n), .en(in_valid), .x(in_data),
      .k_old(k_old), .k_new(k_new), .ff(ff)
   );

   iir_la_loop #(.CW(CW), .CF(CF), .YW(YW)) u_loop (
      .clk(clk), .rst_n(rst_n), .en(in_valid), .k_loop(k_loop),
      .ff(ff), .y(y_acc)
   );

   iir_la_rndsat #(.IW(YW), .SH(CF), .OW(DW)) u_rs_out (.d(y_acc), .q(y_rnd));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpipe     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid & vpipe[LAT-1];
         if (in_valid) begin
            vpipe    <= {vpipe[LAT-2:0], 1'b1};
            out_data <= y_rnd;
         end
      end
   end
endmodule

// File: rtl/iir_la_chk.sv
module iir_la_chk #(
   parameter int DW  = 16,
   parameter int LAT = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 out_valid,
   input logic signed [DW-1:0] out_data
);
   localparam int AW = $clog2(LAT + 1);

   logic [AW-1:0] acc;

   always_ff @(posedge clk) begin
      if (!rst_n)                            acc <= '0;
      else if (in_valid && acc < AW'(LAT))   acc <= acc + 1'b1;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_data == '0));

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));

   // R7
   fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && acc < AW'(LAT)) |=> !out_valid);

   // R5
   steady_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && acc == AW'(LAT)) |=> out_valid);
endmodule

bind iir_la_top iir_la_chk #(.DW(DW), .LAT(FIR_STAGES + 1)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
   .out_valid(out_valid), .out_data(out_data)
);

// File: tb/iir_la_top_test.sv
`timescale 1ns/1ps
module iir_la_top_test;
   localparam int DW  = 16;
   localparam int CW  = 18;
   localparam int STG = 2;
   localparam int LAT = STG + 1;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic signed [DW-1:0] in_data = '0;
   logic                 coef_we = 1'b0;
   logic                 coef_sel = 1'b0;
   logic signed [CW-1:0] coef_wdata = '0;
   logic                 out_valid;
   logic signed [DW-1:0] out_data;

   always #2 clk = ~clk;

   iir_la_top #(.DW(DW), .CW(CW), .CF(16), .GB(4), .FIR_STAGES(STG)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .coef_we(coef_we), .coef_sel(coef_sel), .coef_wdata(coef_wdata),
      .out_valid(out_valid), .out_data(out_data)
   );

   int   n_vec = 0;
   int   n_bad = 0;
   bit   done = 1'b0;
   real  ma = 0.0, mb = 0.0, my = 0.0;
   int   expq[$];
   bit   exactq[$];
   bit   prev_v = 1'b0;
   int   last_out = 0;
   int   strict_left = 0;
   logic [31:0] seed = 32'h1234abcd;

   task automatic report(string tag, int act, int exp);
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
   endtask

   task automatic sample_check();
      int e, d;
      bit ex;
      if (prev_v) begin
         if (expq.size() == LAT + 1) begin
            e  = expq.pop_front();
            ex = exactq.pop_front();
            n_vec++;
            if (out_valid !== 1'b1) report("R5 valid pulse", int'(out_valid), 1);
            else begin
               d = int'(out_data) - e;
               if (strict_left > 0) begin
                  strict_left--;
                  if (d != 0) report("R2 impulse exact", int'(out_data), e);
               end else if (ex && d != 0) report("R4 clamp", int'(out_data), e);
               else if (d > 3 || d < -3) report("R3 tracking", int'(out_data), e);
            end
         end else begin
            n_vec++;
            if (out_valid !== 1'b0) report("R7 fill", int'(out_valid), 0);
         end
      end else begin
         n_vec++;
         if (out_valid !== 1'b0) report("R6 idle valid", int'(out_valid), 0);
         n_vec++;
         if (int'(out_data) != last_out) report("R6 idle hold", int'(out_data), last_out);
      end
      last_out = int'(out_data);
   endtask

   task automatic step(bit v, int x);
      int e;
      bit ex;
      @(negedge clk);
      sample_check();
      in_valid = v;
      in_data  = DW'(x);
      prev_v   = v;
      if (v) begin
         my = ma * my + mb * $itor(x);
         ex = 1'b0;
         if (my >= 32767.0) begin
            e = 32767; ex = (my > 33000.0);
         end else if (my <= -32768.0) begin
            e = -32768; ex = (my < -33000.0);
         end else begin
            e = $rtoi($floor(my + 0.5));
         end
         expq.push_back(e);
         exactq.push_back(ex);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; coef_we = 1'b0; prev_v = 1'b0;
      repeat (3) @(negedge clk);
      n_vec++;
      if (out_valid !== 1'b0) report("R1 reset valid", int'(out_valid), 0);
      n_vec++;
      if (out_data !== '0) report("R1 reset data", int'(out_data), 0);
      rst_n = 1'b1;
      my = 0.0; ma = 0.0; mb = 0.0;
      expq.delete(); exactq.delete();
      last_out = 0;
   endtask

   task automatic write_coef(bit sel, int code);
      step(1'b0, 0);
      coef_we = 1'b1; coef_sel = sel; coef_wdata = CW'(code);
      step(1'b0, 0);
      coef_we = 1'b0;
      if (sel) mb = $itor(code) / 65536.0;
      else     ma = $itor(code) / 65536.0;
      step(1'b0, 0);
      step(1'b0, 0);
   endtask

   function automatic int next_x();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'($signed(seed[30:15]));
   endfunction

   task automatic random_run(int n, int gap_mask);
      int x;
      for (int i = 0; i < n; i++) begin
         x = next_x();
         if ((seed[7:4] & gap_mask[3:0]) == 4'd0) step(1'b0, 0);
         step(1'b1, x);
      end
   endtask

   initial begin
      // R1: reset state
      do_reset();

      // R2: a = 0.75, b = 0.25, exact impulse response
      write_coef(1'b0, 49152);
      write_coef(1'b1, 16384);
      strict_left = 6;
      step(1'b1, 20000);
      for (int i = 0; i < 24; i++) step(1'b1, 0);
      // R3: step at unit DC gain, with idle gaps (R6)
      for (int i = 0; i < 40; i++) begin
         step(1'b1, 16000);
         if (i % 5 == 2) step(1'b0, 0);
      end
      random_run(150, 3);

      // R3: pole near unity, quantised derived coefficients
      do_reset();
      write_coef(1'b0, 58982);
      write_coef(1'b1, 6554);
      for (int i = 0; i < 60; i++) step(1'b1, -20000);
      random_run(200, 7);

      // R4: triple DC gain drives both rails
      do_reset();
      write_coef(1'b0, 32768);
      write_coef(1'b1, 98304);
      for (int i = 0; i < 30; i++) step(1'b1, 30000);
      for (int i = 0; i < 30; i++) step(1'b1, -30000);
      for (int i = 0; i < 30; i++) step(1'b1, 5000);
      random_run(80, 1);

      // R3 / R7: negative pole, fill after a fresh reset
      do_reset();
      write_coef(1'b1, 32768);
      write_coef(1'b0, -32768);
      random_run(150, 3);
      for (int i = 0; i < 4; i++) step(1'b0, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule